// File: doc/BRIEF.md
# Atomic Compare-and-Store Unit

This unit performs one indivisible compare-and-store against a word of memory on behalf of a processor core. The core hands over a pointer, the value it expects to find there and the value it wants to put there. The unit takes the bus lock, reads the word and compares it with the expected value. It writes the replacement only when the two are equal, then drops the lock and answers with the word it sampled. A flag in the answer says whether the store happened.

Because the sampled word always comes back, software can build spin locks, monitor locks, condition variables and lock-free updates of the form x := f(x) on top of this unit. It retries whenever the returned word differs from the one it expected. A pointer that is not word aligned is rejected with a fault answer, and the bus is never touched in that case.

Top module: `cas_unit`

## Requirements
- R1: `req_ready` is high only while the unit is idle; a request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- R2: `mem_lock` stays high from the cycle before the read request until the cycle after the final bus acknowledge, with no gap, and `mem_req` is never high without `mem_lock`.
- R3: A write (`mem_req` and `mem_we` high, `mem_wdata` equal to the new value) is issued only when the word read equals the expected value; the memory word is unchanged otherwise.
- R4: The answer is a single cycle of `rsp_valid`, and `rsp_sample` carries the word that the read returned.
- R5: `mem_lock` rises exactly one cycle before the read request, and it is low in the answer cycle.
- R6: `rsp_done` is high in the answer cycle if and only if the write was performed.
- R7: From acceptance until the answer cycle ends, `req_ready` stays low, and a request presented in that time is neither taken nor able to change the operation in progress.
- R8: When the two low bits of `req_addr` are not both zero, the answer follows one cycle after acceptance with `rsp_fault` high, `rsp_sample` zero and `rsp_done` low, and `mem_lock` and `mem_req` stay low.
- R9: A bus request holds `mem_req`, `mem_addr` and `mem_we` steady until `mem_ack`; any number of wait cycles is accepted.
- R10: During reset `req_ready` is high and `mem_lock`, `mem_req` and `rsp_valid` are low.
- R11: Bus sequence timing: acceptance, one lock cycle, read until acknowledge, one compare cycle, write until acknowledge on a match only, then the answer cycle, then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents an operation |
| req_ready | output | 1 | Unit is idle and will take an operation |
| req_addr | input | AW | Byte pointer of the target word |
| req_expect | input | DW | Value the word is expected to hold |
| req_swap | input | DW | Value to store on a match |
| rsp_valid | output | 1 | Answer cycle |
| rsp_sample | output | DW | Word read under lock (zero on a fault) |
| rsp_done | output | 1 | The store was performed |
| rsp_fault | output | 1 | Pointer was misaligned; bus not used |
| mem_lock | output | 1 | Bus lock, excludes other masters |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes on this edge |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
A corrupted sequencer state shows at the bus pins in the next cycle: the lock would drop early or be missing around a request, the write strobe would appear or be missing, or `req_ready` would rise during an operation. The reference model compares all of these on every clock, so such a fault is reported in the cycle it appears. A wrong captured sample or expected value shows up later, in the compare cycle, as a write that should not happen or a missing one. It also shows as a wrong `rsp_sample`, or as a final memory word that the bench checks after each scenario.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOCK  = 3'd1,
        ST_READ  = 3'd2,
        ST_CMP   = 3'd3,
        ST_WRITE = 3'd4,
        ST_RESP  = 3'd5
    } cas_state_e;

    typedef struct packed {
        cas_state_e st;
        logic       done;
        logic       fault;
    } cas_seq_s;

endpackage

// File: rtl/cas_seq.sv
module cas_seq
    import cas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       addr_bad,
    input  logic       match,
    input  logic       mem_ack,
    output cas_state_e state,
    output logic       done,
    output logic       fault,
    output logic       load_en,
    output logic       cap_en
);

    cas_seq_s seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        load_en = 1'b0;
        cap_en  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    load_en     = 1'b1;
                    seq_d.done  = 1'b0;
                    seq_d.fault = addr_bad;
                    seq_d.st    = addr_bad ? ST_RESP : ST_LOCK;
                end
            end
            ST_LOCK:  seq_d.st = ST_READ;
            ST_READ: begin
                if (mem_ack) begin
                    cap_en   = 1'b1;
                    seq_d.st = ST_CMP;
                end
            end
            ST_CMP:   seq_d.st = match ? ST_WRITE : ST_RESP;
            ST_WRITE: begin
                if (mem_ack) begin
                    seq_d.done = 1'b1;
                    seq_d.st   = ST_RESP;
                end
            end
            ST_RESP:  seq_d.st = ST_IDLE;
            default:  seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, done: 1'b0, fault: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;
    assign done  = seq_q.done;
    assign fault = seq_q.fault;

endmodule

// File: rtl/cas_dpath.sv
module cas_dpath #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic          cap_en,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_expect,
    input  logic [DW-1:0] req_swap,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] swap_q,
    output logic [DW-1:0] sample_q,
    output logic          match,
    output logic          addr_bad
);

    localparam int OFS_W = (DW / 8 > 1) ? $clog2(DW / 8) : 1;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] expv;
        logic [DW-1:0] swap;
        logic [DW-1:0] sample;
    } dp_s;

    dp_s dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (load_en) begin
            dp_d.addr   = req_addr;
            dp_d.expv   = req_expect;
            dp_d.swap   = req_swap;
            dp_d.sample = '0;
        end else if (cap_en) begin
            dp_d.sample = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign addr_bad = |req_addr[OFS_W-1:0];
    assign match    = (dp_q.sample == dp_q.expv);
    assign addr_q   = dp_q.addr;
    assign swap_q   = dp_q.swap;
    assign sample_q = dp_q.sample;

endmodule

// File: rtl/cas_unit.sv
module cas_unit
    import cas_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_expect,
    input  logic [DW-1:0] req_swap,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_sample,
    output logic          rsp_done,
    output logic          rsp_fault,
    output logic          mem_lock,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    cas_state_e state;
    logic       done, fault, load_en, cap_en, match, addr_bad;
    logic       take;

    assign take = req_valid && req_ready;

    cas_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .addr_bad  (addr_bad),
        .match     (match),
        .mem_ack   (mem_ack),
        .state     (state),
        .done      (done),
        .fault     (fault),
        .load_en   (load_en),
        .cap_en    (cap_en)
    );

    cas_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en && take),
        .cap_en     (cap_en),
        .req_addr   (req_addr),
        .req_expect (req_expect),
        .req_swap   (req_swap),
        .mem_rdata  (mem_rdata),
        .addr_q     (mem_addr),
        .swap_q     (mem_wdata),
        .sample_q   (rsp_sample),
        .match      (match),
        .addr_bad   (addr_bad)
    );

    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_lock  = (state == ST_LOCK) || (state == ST_READ) ||
                    (state == ST_CMP)  || (state == ST_WRITE);
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        rsp_valid = (state == ST_RESP);
        rsp_done  = rsp_valid && done;
        rsp_fault = rsp_valid && fault;
    end

endmodule

// File: rtl/cas_unit_chk.sv
module cas_unit_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [DW-1:0] req_expect,
    input logic [DW-1:0] req_swap,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_sample,
    input logic          rsp_done,
    input logic          rsp_fault,
    input logic          mem_lock,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata
);

    logic [AW-1:0] ck_addr;
    logic [DW-1:0] ck_exp, ck_swap, ck_rd;
    logic          ck_wrote;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_addr  <= '0;
            ck_exp   <= '0;
            ck_swap  <= '0;
            ck_rd    <= '0;
            ck_wrote <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                ck_addr  <= req_addr;
                ck_exp   <= req_expect;
                ck_swap  <= req_swap;
                ck_wrote <= 1'b0;
            end
            if (mem_req && !mem_we && mem_ack) ck_rd <= mem_rdata;
            if (mem_req && mem_we && mem_ack)  ck_wrote <= 1'b1;
        end
    end

    // R2: no bus access outside the lock
    p_lock_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock);

    // R5: lock leads the read by a cycle
    p_lock_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_lock) |-> !mem_req);

    // R5: lock released by the answer cycle
    p_rsp_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_lock);

    // R7: no new operation taken while busy
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_lock || rsp_valid) |-> !req_ready);

    // R3: write only after a matching read, with the captured new value
    p_write_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (ck_rd == ck_exp && mem_wdata == ck_swap));

    // R9: access target is the accepted pointer and is held until ack
    p_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr == ck_addr));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: success flag reports the write
    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_done == ck_wrote));

    // R8: fault answer comes straight after acceptance, empty
    p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> ($past(req_ready) && !rsp_done && rsp_sample == '0));

endmodule

bind cas_unit cas_unit_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_cas_unit.sv
`timescale 1ns/1ps
module test_cas_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0, req_expect = '0, req_swap = '0;
    logic        rsp_valid, rsp_done, rsp_fault;
    logic [31:0] rsp_sample;
    logic        mem_lock, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2 clk = ~clk;

    cas_unit i_cas_unit (.*);

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wait_cfg = 0;
    int wcnt   = 0;
    logic [31:0] mem [16];

    // reference model state
    int          m_ph = 0;
    logic [31:0] m_addr = '0, m_old = '0, m_new = '0, m_smp = '0;
    logic        m_ok = 1'b0, m_bad = 1'b0, m_acc = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model and memory, using values present before the edge
    always @(posedge clk) begin
        m_acc = 1'b0;
        if (rst_n && mem_req && mem_we && mem_ack) mem[mem_addr[5:2]] = mem_wdata;
        if (!rst_n) begin
            m_ph = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin
                    m_acc = 1'b1;
                    m_smp = '0;
                    m_ok  = 1'b0;
                    m_addr = req_addr; m_old = req_expect; m_new = req_swap;
                    m_bad = (req_addr[1:0] != 2'b00);
                    m_ph  = m_bad ? 5 : 1;
                end
                1: m_ph = 2;
                2: if (mem_ack) begin m_smp = mem_rdata; m_ph = 3; end
                3: m_ph = (m_smp == m_old) ? 4 : 5;
                4: if (mem_ack) begin m_ok = 1'b1; m_ph = 5; end
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle comparison and bus responder
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R1 req_ready", {31'd0, req_ready}, {31'd0, m_ph == 0});
            chk("R2 mem_lock", {31'd0, mem_lock}, {31'd0, m_ph >= 1 && m_ph <= 4});
            chk("R11 mem_req", {31'd0, mem_req}, {31'd0, m_ph == 2 || m_ph == 4});
            chk("R3 mem_we", {31'd0, mem_we}, {31'd0, m_ph == 4});
            chk("R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_ph == 5});
            if (m_ph == 2 || m_ph == 4) chk("R9 mem_addr", mem_addr, m_addr);
            if (m_ph == 4) chk("R3 mem_wdata", mem_wdata, m_new);
            if (m_ph == 5) begin
                chk("R4 rsp_sample", rsp_sample, m_smp);
                chk("R6 rsp_done", {31'd0, rsp_done}, {31'd0, m_ok});
                chk("R8 rsp_fault", {31'd0, rsp_fault}, {31'd0, m_bad});
            end
        end
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= wait_cfg) begin
                mem_ack = 1'b1;
                mem_rdata = mem[mem_addr[5:2]];
            end else begin
                wcnt++;
            end
        end
        if (cyc > 20000) begin
            fails++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic do_cas(input logic [31:0] a, input logic [31:0] o, input logic [31:0] n,
                          input bit busy_poke,
                          output logic [31:0] smp, output logic ok, output logic flt);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_expect = o; req_swap = n;
        do @(negedge clk); while (!m_acc);
        if (busy_poke) begin
            // R7: stray request while busy, misaligned and different values
            req_addr = a + 32'd2; req_expect = 32'hDEAD; req_swap = 32'hBEEF;
        end else begin
            req_valid = 1'b0;
        end
        while (!rsp_valid) @(negedge clk);
        smp = rsp_sample; ok = rsp_done; flt = rsp_fault;
        req_valid = 1'b0;
    endtask

    logic [31:0] s;
    logic        ok, flt;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h100 + i;
        repeat (2) @(negedge clk);
        chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R10 reset lock", {31'd0, mem_lock}, 32'd0);
        chk("R10 reset req", {31'd0, mem_req}, 32'd0);
        chk("R10 reset rsp", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;

        // R3 R6 match with no wait states
        mem[1] = 32'd5;
        do_cas(32'h4, 32'd5, 32'd9, 1'b0, s, ok, flt);
        chk("R4 match sample", s, 32'd5);
        chk("R6 match done", {31'd0, ok}, 32'd1);
        @(negedge clk);
        chk("R3 match stored", mem[1], 32'd9);

        // R3 mismatch leaves memory alone
        do_cas(32'h4, 32'd5, 32'd7, 1'b0, s, ok, flt);
        chk("R4 miss sample", s, 32'd9);
        chk("R6 miss done", {31'd0, ok}, 32'd0);
        @(negedge clk);
        chk("R3 miss unchanged", mem[1], 32'd9);

        // R8 misaligned pointer
        do_cas(32'h6, 32'd9, 32'd1, 1'b0, s, ok, flt);
        chk("R8 fault flag", {31'd0, flt}, 32'd1);
        chk("R8 fault sample", s, 32'd0);
        @(negedge clk);
        chk("R8 word untouched", mem[1], 32'd9);

        // R9 spin lock with wait states
        wait_cfg = 3;
        mem[2] = 32'd0;
        do_cas(32'h8, 32'd0, 32'd1, 1'b0, s, ok, flt);
        chk("R9 acquire done", {31'd0, ok}, 32'd1);
        do_cas(32'h8, 32'd0, 32'd1, 1'b0, s, ok, flt);
        chk("R9 contended sample", s, 32'd1);
        chk("R9 contended done", {31'd0, ok}, 32'd0);
        do_cas(32'h8, 32'd1, 32'd0, 1'b0, s, ok, flt);
        chk("R9 release done", {31'd0, ok}, 32'd1);
        @(negedge clk);
        chk("R9 lock free", mem[2], 32'd0);

        // R7 request held during an operation must be ignored
        wait_cfg = 1;
        mem[4] = 32'd70;
        do_cas(32'h10, 32'd70, 32'd71, 1'b1, s, ok, flt);
        chk("R7 busy no fault", {31'd0, flt}, 32'd0);
        chk("R7 busy done", {31'd0, ok}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 busy idle", {31'd0, mem_lock}, 32'd0);
        chk("R7 busy word", mem[4], 32'd71);

        // R11 atomic increment with retry
        mem[3] = 32'd40;
        for (int k = 0; k < 3; k++) begin
            logic [31:0] guess;
            guess = 32'd0;
            do_cas(32'hC, guess, guess + 1, 1'b0, s, ok, flt);
            while (!ok) begin
                guess = s;
                do_cas(32'hC, guess, guess + 1, 1'b0, s, ok, flt);
            end
        end
        @(negedge clk);
        chk("R11 increment result", mem[3], 32'd43);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule